// File: doc/BRIEF.md
# Atomic Read-Modify-Write Memory Unit

This block sits on the memory side of a multi-requester system. It owns a small word-addressed store and carries out indivisible operations on it. Supported operations are plain load, plain store, test-and-set, exchange, compare-and-swap and fetch-and-increment. Each accepted request reads the addressed word, decides whether to write a new value, and commits that write in the same clock cycle. No other access can fall between the read and the write.

Several requesters share one unit. Each has its own valid/ready request port, and a round-robin arbiter accepts exactly one request per cycle. One cycle after acceptance, a shared response channel returns three things: the identity of the requester, the word as it was before the operation, and a flag. The flag is meaningful only for compare-and-swap.

Software builds spin locks on test-and-set. A returned zero means the lock is taken. Any nonzero return means the attempt failed. A plain store of zero frees the lock.

Top module: `atomic_rmw_unit`

## Requirements
- R1: After synchronous reset, `rsp_valid` is 0 and every word of the store reads as 0.
- R2: Load (op code 0) returns the addressed word on `rsp_old` and leaves the word unchanged.
- R3: Store (op code 1) writes `req_wdata` to the word and returns the previous word.
- R4: Test-and-set (op code 2) returns the previous word and writes 1. A returned 0 means the lock was acquired; a nonzero return means the attempt failed.
- R5: Exchange (op code 3) writes `req_wdata` and returns the previous word.
- R6: Compare-and-swap (op code 4) writes `req_wdata` only when the stored word equals `req_cmp`. It sets `rsp_flag` to 1 on a match and to 0 otherwise. On a mismatch the word is unchanged.
- R7: Fetch-and-increment (op code 5) returns the previous word and stores that word plus one, modulo 2^DATA_W, so all-ones becomes 0.
- R8: At most one `req_ready` bit is high in any cycle, and only for a requester whose `req_valid` is high. While every requester is held valid, grants rotate in increasing index order and wrap from the last requester to the first.
- R9: A request accepted at a clock edge (valid and ready both high) yields `rsp_valid` high after that edge. At that point `rsp_id` is the requester index, and `rsp_flag` is 0 for any op other than compare-and-swap.
- R10: When two test-and-set requests on the same word arrive in the same cycle, they are carried out one after the other. Exactly one of them sees 0. After a release store, the losing requester's next test-and-set sees 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | N_REQ | Request present, one bit per requester |
| req_ready | output | N_REQ | Request accepted this cycle, one bit per requester |
| req_op | input | N_REQ*3 | Op code per requester |
| req_addr | input | N_REQ*ADDR_W | Word address per requester |
| req_wdata | input | N_REQ*DATA_W | Store/exchange/new value per requester |
| req_cmp | input | N_REQ*DATA_W | Expected value for compare-and-swap |
| rsp_valid | output | 1 | Response present |
| rsp_id | output | ID_W | Index of the requester being answered |
| rsp_old | output | DATA_W | Word value before the operation |
| rsp_flag | output | 1 | Compare-and-swap success |

## Verification
The case that matters most is two requesters aiming at the same lock word in the same cycle. The bench raises two test-and-set requests on one address at the same falling edge. It then checks that only one is accepted per edge, and that the two responses arrive on consecutive cycles with different ids. Of the two returned old values, exactly one must be zero. A release store from a third requester follows, and the loser's retry is expected to return zero.

// File: rtl/atomu_pkg.sv
package atomu_pkg;

    localparam int OP_W = 3;

    typedef enum logic [OP_W-1:0] {
        OP_LOAD  = 3'd0,
        OP_STORE = 3'd1,
        OP_TAS   = 3'd2,
        OP_SWAP  = 3'd3,
        OP_CAS   = 3'd4,
        OP_FINC  = 3'd5
    } op_e;

    typedef struct packed {
        logic wr;
        logic flag;
    } rmw_ctl_t;

    function automatic logic op_has_flag(op_e op);
        return op == OP_CAS;
    endfunction

endpackage

// File: rtl/rr_arbiter.sv
module rr_arbiter #(
    parameter int N    = 3,
    parameter int ID_W = $clog2(N)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [N-1:0]    valid,
    output logic [N-1:0]    grant,
    output logic [ID_W-1:0] gidx
);
    logic [ID_W-1:0] last;
    logic [N-1:0]    prev_gnt;

    always_comb begin
        logic found;
        found = 1'b0;
        grant = '0;
        gidx  = '0;
        for (int off = 1; off <= N; off++) begin
            int c;
            c = (int'(last) + off) % N;
            if (!found && valid[c]) begin
                found    = 1'b1;
                grant[c] = 1'b1;
                gidx     = c[ID_W-1:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            last     <= ID_W'(N - 1);
            prev_gnt <= '0;
        end else begin
            prev_gnt <= grant;
            if (|valid) last <= gidx;
        end
    end

    assert_onehot_grant_R8: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant));
    assert_grant_needs_valid_R8: assert property (@(posedge clk) disable iff (rst)
        (grant & ~valid) == '0);
    assert_no_repeat_when_others_wait_R8: assert property (@(posedge clk) disable iff (rst)
        (grant != '0 && grant == prev_gnt) |-> ((valid & ~grant) == '0));
endmodule

// File: rtl/rmw_alu.sv
module rmw_alu
    import atomu_pkg::*;
#(
    parameter int DW = 16
) (
    input  op_e           op,
    input  logic [DW-1:0] old_val,
    input  logic [DW-1:0] wdata,
    input  logic [DW-1:0] cmp,
    output logic [DW-1:0] new_val,
    output rmw_ctl_t      ctl
);
    always_comb begin
        new_val  = old_val;
        ctl.wr   = 1'b0;
        ctl.flag = 1'b0;
        case (op)
            OP_STORE, OP_SWAP: begin
                new_val = wdata;
                ctl.wr  = 1'b1;
            end
            OP_TAS: begin
                new_val = DW'(1);
                ctl.wr  = 1'b1;
            end
            OP_CAS: begin
                ctl.flag = (old_val == cmp);
                ctl.wr   = ctl.flag;
                new_val  = wdata;
            end
            OP_FINC: begin
                new_val = old_val + DW'(1);
                ctl.wr  = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/word_store.sv
module word_store #(
    parameter int DW = 16,
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] addr,
    output logic [DW-1:0] rdata,
    input  logic          we,
    input  logic [DW-1:0] wdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    assign rdata = mem[addr];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we) begin
            mem[addr] <= wdata;
        end
    end

    assert_write_lands_R3: assert property (@(posedge clk) disable iff (rst)
        we |=> mem[$past(addr)] == $past(wdata));
endmodule

// File: rtl/atomic_rmw_unit.sv
module atomic_rmw_unit
    import atomu_pkg::*;
#(
    parameter int N_REQ  = 3,
    parameter int DATA_W = 16,
    parameter int ADDR_W = 4,
    localparam int ID_W  = $clog2(N_REQ)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [N_REQ-1:0]         req_valid,
    output logic [N_REQ-1:0]         req_ready,
    input  logic [N_REQ*OP_W-1:0]    req_op,
    input  logic [N_REQ*ADDR_W-1:0]  req_addr,
    input  logic [N_REQ*DATA_W-1:0]  req_wdata,
    input  logic [N_REQ*DATA_W-1:0]  req_cmp,
    output logic                     rsp_valid,
    output logic [ID_W-1:0]          rsp_id,
    output logic [DATA_W-1:0]        rsp_old,
    output logic                     rsp_flag
);
    logic [ID_W-1:0]   gidx;
    logic              any_gnt;
    op_e               sel_op;
    logic [ADDR_W-1:0] sel_addr;
    logic [DATA_W-1:0] sel_wdata, sel_cmp, old_val, new_val;
    rmw_ctl_t          ctl;
    op_e               rsp_op_q;

    rr_arbiter #(.N(N_REQ), .ID_W(ID_W)) i_arb (
        .clk(clk), .rst(rst), .valid(req_valid), .grant(req_ready), .gidx(gidx)
    );

    assign any_gnt   = |req_ready;
    assign sel_op    = op_e'(req_op[gidx*OP_W +: OP_W]);
    assign sel_addr  = req_addr[gidx*ADDR_W +: ADDR_W];
    assign sel_wdata = req_wdata[gidx*DATA_W +: DATA_W];
    assign sel_cmp   = req_cmp[gidx*DATA_W +: DATA_W];

    word_store #(.DW(DATA_W), .AW(ADDR_W)) i_store (
        .clk(clk), .rst(rst), .addr(sel_addr), .rdata(old_val),
        .we(any_gnt && ctl.wr), .wdata(new_val)
    );

    rmw_alu #(.DW(DATA_W)) i_alu (
        .op(sel_op), .old_val(old_val), .wdata(sel_wdata), .cmp(sel_cmp),
        .new_val(new_val), .ctl(ctl)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_id    <= '0;
            rsp_old   <= '0;
            rsp_flag  <= 1'b0;
            rsp_op_q  <= OP_LOAD;
        end else begin
            rsp_valid <= any_gnt;
            if (any_gnt) begin
                rsp_id   <= gidx;
                rsp_old  <= old_val;
                rsp_flag <= ctl.flag;
                rsp_op_q <= sel_op;
            end
        end
    end

    assert_rsp_follows_grant_R9: assert property (@(posedge clk) disable iff (rst)
        any_gnt |=> rsp_valid);
    assert_rsp_id_matches_R9: assert property (@(posedge clk) disable iff (rst)
        any_gnt |=> rsp_id == $past(gidx));
    assert_flag_only_cas_R6: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_flag) |-> op_has_flag(rsp_op_q));
endmodule

// File: tb/test_atomic_rmw_unit.sv
module test_atomic_rmw_unit;
    localparam int N = 3, DW = 16, AW = 4;

    logic clk = 1'b0, rst = 1'b1;
    logic [N-1:0]      req_valid = '0;
    logic [N-1:0]      req_ready;
    logic [N*3-1:0]    req_op = '0;
    logic [N*AW-1:0]   req_addr = '0;
    logic [N*DW-1:0]   req_wdata = '0, req_cmp = '0;
    logic              rsp_valid, rsp_flag;
    logic [1:0]        rsp_id;
    logic [DW-1:0]     rsp_old;
    int tests = 0, fails = 0;

    always #4 clk = ~clk;

    atomic_rmw_unit #(.N_REQ(N), .DATA_W(DW), .ADDR_W(AW)) i_atomic_rmw_unit (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_addr(req_addr), .req_wdata(req_wdata), .req_cmp(req_cmp),
        .rsp_valid(rsp_valid), .rsp_id(rsp_id), .rsp_old(rsp_old), .rsp_flag(rsp_flag)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic load_req(input int id, input logic [2:0] op, input logic [3:0] a,
                            input logic [15:0] wd, input logic [15:0] cmp);
        req_op[id*3 +: 3]     = op;
        req_addr[id*AW +: AW] = a;
        req_wdata[id*DW +: DW] = wd;
        req_cmp[id*DW +: DW]   = cmp;
        req_valid[id]          = 1'b1;
    endtask

    task automatic do_op(input int id, input logic [2:0] op, input logic [3:0] a,
                         input logic [15:0] wd, input logic [15:0] cmp,
                         output logic [15:0] old, output logic fl, output int rid, output logic vld);
        @(negedge clk);
        load_req(id, op, a, wd, cmp);
        #1;
        while (!req_ready[id]) begin @(negedge clk); #1; end
        @(posedge clk);
        @(negedge clk);
        req_valid[id] = 1'b0;
        old = rsp_old; fl = rsp_flag; rid = rsp_id; vld = rsp_valid;
    endtask

    logic [15:0] o; logic f, v; int r;

    task automatic t_reset;
        check("R1 rsp_valid after reset", rsp_valid, 0);
        do_op(0, 3'd0, 4'd0, 0, 0, o, f, r, v);
        check("R1 word0 zero", o, 0);
        do_op(1, 3'd0, 4'd15, 0, 0, o, f, r, v);
        check("R1 word15 zero", o, 0);
        check("R9 rsp_valid", v, 1);
        check("R9 rsp_id", r, 1);
    endtask

    task automatic t_store_load;
        do_op(2, 3'd1, 4'd3, 16'hA5C3, 0, o, f, r, v);
        check("R3 store returns old", o, 0);
        check("R9 flag 0 on store", f, 0);
        do_op(0, 3'd0, 4'd3, 0, 0, o, f, r, v);
        check("R2 load value", o, 16'hA5C3);
        do_op(0, 3'd0, 4'd3, 0, 0, o, f, r, v);
        check("R2 load leaves word", o, 16'hA5C3);
    endtask

    task automatic t_tas_swap;
        do_op(1, 3'd2, 4'd7, 16'h5555, 0, o, f, r, v);
        check("R4 first tas sees 0", o, 0);
        do_op(1, 3'd2, 4'd7, 0, 0, o, f, r, v);
        check("R4 second tas sees 1", o, 1);
        do_op(2, 3'd3, 4'd7, 16'hBEEF, 0, o, f, r, v);
        check("R5 swap returns old", o, 1);
        do_op(0, 3'd0, 4'd7, 0, 0, o, f, r, v);
        check("R5 swap wrote", o, 16'hBEEF);
    endtask

    task automatic t_cas;
        do_op(0, 3'd4, 4'd7, 16'h1234, 16'h0BAD, o, f, r, v);
        check("R6 cas miss old", o, 16'hBEEF);
        check("R6 cas miss flag", f, 0);
        do_op(0, 3'd0, 4'd7, 0, 0, o, f, r, v);
        check("R6 cas miss no write", o, 16'hBEEF);
        do_op(2, 3'd4, 4'd7, 16'h1234, 16'hBEEF, o, f, r, v);
        check("R6 cas hit flag", f, 1);
        do_op(0, 3'd0, 4'd7, 0, 0, o, f, r, v);
        check("R6 cas hit wrote", o, 16'h1234);
    endtask

    task automatic t_finc;
        do_op(1, 3'd1, 4'd9, 16'hFFFE, 0, o, f, r, v);
        do_op(1, 3'd5, 4'd9, 0, 0, o, f, r, v);
        check("R7 finc old", o, 16'hFFFE);
        do_op(1, 3'd5, 4'd9, 0, 0, o, f, r, v);
        check("R7 finc old allones", o, 16'hFFFF);
        do_op(1, 3'd0, 4'd9, 0, 0, o, f, r, v);
        check("R7 finc wraps to 0", o, 0);
    endtask

    task automatic t_round_robin;
        int ids[7];
        @(negedge clk);
        for (int i = 0; i < N; i++) load_req(i, 3'd0, 4'd0, 0, 0);
        for (int k = 0; k < 7; k++) begin
            #1;
            check("R8 one ready", $countones(req_ready), 1);
            @(posedge clk); @(negedge clk);
            ids[k] = rsp_id;
        end
        req_valid = '0;
        for (int k = 0; k < 6; k++)
            check("R8 rotation order", ids[k+1], (ids[k] + 1) % N);
    endtask

    task automatic t_contention;
        logic [15:0] o0, o1; int id0, id1, loser;
        @(negedge clk);
        load_req(0, 3'd2, 4'd5, 0, 0);
        load_req(1, 3'd2, 4'd5, 0, 0);
        #1;
        check("R10 single grant", $countones(req_ready), 1);
        @(posedge clk); @(negedge clk);
        o0 = rsp_old; id0 = rsp_id;
        req_valid[id0] = 1'b0;
        #1;
        check("R10 other granted next", req_ready[1-id0], 1);
        @(posedge clk); @(negedge clk);
        o1 = rsp_old; id1 = rsp_id;
        req_valid = '0;
        check("R10 ids differ", (id0 != id1), 1);
        check("R10 exactly one zero", int'(o0 == 0) + int'(o1 == 0), 1);
        loser = (o0 == 0) ? id1 : id0;
        do_op(loser, 3'd2, 4'd5, 0, 0, o, f, r, v);
        check("R10 still held", o, 1);
        do_op(2, 3'd1, 4'd5, 0, 0, o, f, r, v);
        do_op(loser, 3'd2, 4'd5, 0, 0, o, f, r, v);
        check("R10 acquired after release", o, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        t_reset();
        t_store_load();
        t_tas_swap();
        t_cas();
        t_finc();
        t_round_robin();
        t_contention();
        repeat (2) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule